// File: doc/BRIEF.md
# Programmable Fill-Threshold FIFO

This block is a single-clock first-in first-out buffer for 9-bit words with a parameterized depth. A write strobe stores the word on the input bus, and a read strobe presents the oldest stored word on a registered output. Three active-low flags report the buffer state: empty, full, and a fill flag. The fill flag goes low once the number of stored words exceeds a threshold that can be programmed.

The threshold is set only while reset is held. During reset, a write strobe loads a 9-bit code from the data input bus. A read strobe loads the code from a separate configuration bus instead. The threshold is the code multiplied by a step of DEPTH/512 words. If no code is loaded during a reset window, the threshold is half the depth.

A retransmit strobe rewinds the read side to the first stored word and leaves the write side alone, so a block of data can be replayed. A cascade-mode input turns off both the retransmit and the fill flag, for use where several buffers are chained in depth.

Top module: `fill_flag_fifo`

## Requirements
- R1: While reset is high, the next edge sets empty_n low, full_n high and fill_n high, and both pointers return to the first location.
- R2: Words are read out in the same order they were written. The read word appears on rd_data one clock after the read strobe.
- R3: While reset is high, wr_stb loads wr_data as the threshold code, and the threshold becomes code × (DEPTH/512) words.
- R4: While reset is high, rd_stb without wr_stb loads cfg_code as the threshold code. If both strobes are high, wr_data takes priority.
- R5: If no code is loaded during a reset window, the threshold is DEPTH/2 words. A reset window is a continuous stretch of reset-high cycles.
- R6: fill_n goes low after the write that makes the stored count greater than the threshold. It returns high after the read that brings the count back to the threshold or below.
- R7: With no reads since reset, full_n goes low after exactly DEPTH writes. A write while full_n is low changes neither the contents nor the write pointer.
- R8: A read while empty_n is low leaves the read pointer unchanged, and rd_data keeps its previous value.
- R9: A retransmit strobe returns the read pointer to the first location and leaves the write pointer unchanged. Read and write strobes in the same cycle are ignored. The flags are then recomputed from the writes made since reset.
- R10: A read and a write in the same cycle, with the buffer neither empty nor full, leave the stored count and all flags unchanged.
- R11: With cascade_mode high, fill_n stays high and retransmit strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the threshold load window |
| wr_stb | input | 1 | Write strobe; during reset it loads the threshold code from wr_data |
| wr_data | input | 9 | Write word, and the threshold code source during reset |
| rd_stb | input | 1 | Read strobe; during reset it loads the threshold code from cfg_code |
| cfg_code | input | 9 | Alternative threshold code source |
| rt_stb | input | 1 | Retransmit: rewinds the read pointer |
| cascade_mode | input | 1 | Disables retransmit and the fill flag |
| rd_data | output | 9 | Registered read word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| fill_n | output | 1 | Low when the stored count exceeds the threshold |

## Verification
The checker watches the local flag rules on every cycle:
- the flag values after reset;
- writes blocked while full and reads blocked while empty;
- full and empty never low together;
- flags that stay stable through a simultaneous read and write;
- fill_n held high in cascade mode.

Other behaviour depends on a history of operations, and only the bench scenarios can show it:
- the data order;
- the exact write counts at which full_n and fill_n change;
- the threshold that results from each code source or from the default;
- the replay of data after a retransmit.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
    localparam int CODE_W = 9;

    typedef struct packed {
        logic wr;
        logic rd;
        logic rt;
    } fifo_op_t;

    function automatic int unsigned code_to_offset(input logic [CODE_W-1:0] code,
                                                   input int unsigned step);
        return int'(code) * step;
    endfunction
endpackage

// File: rtl/fill_cfg.sv
module fill_cfg #(
    parameter int DEPTH = 1024,
    parameter int CW    = 11
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_stb,
    input  logic [pfifo_pkg::CODE_W-1:0]  wr_code,
    input  logic                          rd_stb,
    input  logic [pfifo_pkg::CODE_W-1:0]  bus_code,
    output logic [CW-1:0]                 offset
);
    localparam int STEP = DEPTH >> pfifo_pkg::CODE_W;

    logic                         was_rst;
    logic                         loaded;
    logic [pfifo_pkg::CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (rst) begin
            if (wr_stb) begin
                code_q <= wr_code;
                loaded <= 1'b1;
            end else if (rd_stb) begin
                code_q <= bus_code;
                loaded <= 1'b1;
            end else if (!was_rst) begin
                loaded <= 1'b0;
            end
        end
    end

    always_comb begin
        if (loaded)
            offset = CW'(pfifo_pkg::code_to_offset(code_q, STEP));
        else
            offset = CW'(DEPTH / 2);
    end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pfifo_pkg::fifo_op_t  op,
    input  logic [AW:0]          offset,
    input  logic                 fill_en,
    output logic                 wr_ok,
    output logic                 rd_ok,
    output logic [AW-1:0]        waddr,
    output logic [AW-1:0]        raddr,
    output logic                 empty_n,
    output logic                 full_n,
    output logic                 fill_n
);
    logic [AW:0] wptr, rptr, cnt, cnt_nx;

    assign wr_ok = !rst && !op.rt && op.wr && full_n;
    assign rd_ok = !rst && !op.rt && op.rd && empty_n;
    assign waddr = wptr[AW-1:0];
    assign raddr = rptr[AW-1:0];

    always_comb begin
        if (op.rt)
            cnt_nx = wptr;
        else
            cnt_nx = cnt + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            empty_n <= 1'b0;
            full_n  <= 1'b1;
            fill_n  <= 1'b1;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (op.rt) rptr <= '0;
            else if (rd_ok) rptr <= rptr + 1'b1;
            cnt     <= cnt_nx;
            empty_n <= (cnt_nx != '0);
            full_n  <= (cnt_nx != (AW+1)'(DEPTH));
            fill_n  <= !(fill_en && (cnt_nx > offset));
        end
    end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int DW    = 9,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fill_flag_fifo.sv
module fill_flag_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_stb,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_stb,
    input  logic [pfifo_pkg::CODE_W-1:0] cfg_code,
    input  logic                         rt_stb,
    input  logic                         cascade_mode,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         empty_n,
    output logic                         full_n,
    output logic                         fill_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    pfifo_pkg::fifo_op_t op;
    logic [CW-1:0] offset;
    logic          wr_ok, rd_ok;
    logic [AW-1:0] waddr, raddr;

    assign op.wr = wr_stb;
    assign op.rd = rd_stb;
    assign op.rt = rt_stb && !cascade_mode;

    fill_cfg #(.DEPTH(DEPTH), .CW(CW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_code  (wr_data[pfifo_pkg::CODE_W-1:0]),
        .rd_stb   (rd_stb),
        .bus_code (cfg_code),
        .offset   (offset)
    );

    fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .offset  (offset),
        .fill_en (!cascade_mode),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .waddr   (waddr),
        .raddr   (raddr),
        .empty_n (empty_n),
        .full_n  (full_n),
        .fill_n  (fill_n)
    );

    fifo_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/fifo_checks.sv
module fifo_checks #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_stb,
    input logic          rd_stb,
    input logic          rt_stb,
    input logic          cascade_mode,
    input logic [DW-1:0] rd_data,
    input logic          empty_n,
    input logic          full_n,
    input logic          fill_n
);
    assert_reset_flags_R1: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n && fill_n));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_stb && !rd_stb && !rt_stb) |=> !full_n);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(!full_n && !empty_n));

    assert_empty_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_stb && !wr_stb && !rt_stb) |=> (!empty_n && $stable(rd_data)));

    assert_simul_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_stb && !rt_stb && empty_n && full_n && $stable(cascade_mode))
        |=> ($stable(empty_n) && $stable(full_n) && $stable(fill_n)));

    assert_cascade_fill_R11: assert property (@(posedge clk) disable iff (rst)
        cascade_mode |=> fill_n);

    assert_fill_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(fill_n) |-> ($past(wr_stb) || $past(rt_stb) || $past(cascade_mode, 2)));
endmodule

bind fill_flag_fifo fifo_checks #(.DW(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .rt_stb       (rt_stb),
    .cascade_mode (cascade_mode),
    .rd_data      (rd_data),
    .empty_n      (empty_n),
    .full_n       (full_n),
    .fill_n       (fill_n)
);

// File: tb/sim_fill_flag_fifo.sv
`timescale 1ns/1ps
module sim_fill_flag_fifo;
    localparam int DEPTH = 1024;
    localparam int STEP  = DEPTH / 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, rt_stb = 1'b0, cascade_mode = 1'b0;
    logic [8:0] wr_data = '0, cfg_code = '0;
    logic [8:0] rd_data;
    logic       empty_n, full_n, fill_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fill_flag_fifo #(.DATA_W(9), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .cfg_code(cfg_code), .rt_stb(rt_stb),
        .cascade_mode(cascade_mode), .rd_data(rd_data),
        .empty_n(empty_n), .full_n(full_n), .fill_n(fill_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_stb = 0; rd_stb = 0; rt_stb = 0;
    endtask

    // mode 0: no load, 1: load via wr_data, 2: load via cfg_code, 3: both strobes
    task automatic do_reset(input int mode, input int wcode, input int bcode);
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        wr_data = 9'(wcode); cfg_code = 9'(bcode);
        wr_stb = (mode == 1 || mode == 3);
        rd_stb = (mode == 2 || mode == 3);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic push(input int v);
        wr_stb = 1; wr_data = 9'(v);
        @(negedge clk);
        wr_stb = 0;
    endtask

    task automatic pop_expect(input string tag, input int v);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        check(tag, int'(rd_data), v);
    endtask

    task automatic t_reset_state();
        do_reset(0, 0, 0);
        check("R1 empty_n", int'(empty_n), 0);
        check("R1 full_n", int'(full_n), 1);
        check("R1 fill_n", int'(fill_n), 1);
    endtask

    task automatic t_order();
        do_reset(0, 0, 0);
        for (int k = 0; k < 5; k++) push(9'h0A0 + k * 13);
        check("R2 empty_n after writes", int'(empty_n), 1);
        for (int k = 0; k < 5; k++) pop_expect("R2 order", 9'h0A0 + k * 13);
        check("R2 empty_n after reads", int'(empty_n), 0);
    endtask

    task automatic t_wr_code();
        do_reset(1, 3, 0);
        for (int k = 0; k < 3 * STEP; k++) push(k);
        check("R3 at threshold", int'(fill_n), 1);
        push(99);
        check("R3 above threshold", int'(fill_n), 0);
    endtask

    task automatic t_bus_code();
        do_reset(2, 0, 2);
        for (int k = 0; k < 2 * STEP; k++) push(k);
        check("R4 bus at threshold", int'(fill_n), 1);
        push(7);
        check("R4 bus above threshold", int'(fill_n), 0);
        do_reset(3, 1, 5);
        for (int k = 0; k < STEP; k++) push(k);
        check("R4 both strobes at threshold", int'(fill_n), 1);
        push(7);
        check("R4 both strobes above", int'(fill_n), 0);
    endtask

    task automatic t_default_and_fill();
        do_reset(1, 4, 0);
        do_reset(0, 0, 0);
        for (int k = 0; k < DEPTH / 2; k++) push(k);
        check("R5 default at half", int'(fill_n), 1);
        push(1);
        check("R5 R6 above half", int'(fill_n), 0);
        pop_expect("R2 head", 0);
        check("R6 back to threshold", int'(fill_n), 1);
    endtask

    task automatic t_full();
        do_reset(0, 0, 0);
        for (int k = 0; k < DEPTH - 1; k++) push((k * 7 + 3) & 9'h1FF);
        check("R7 not full at DEPTH-1", int'(full_n), 1);
        push(((DEPTH - 1) * 7 + 3) & 9'h1FF);
        check("R7 full at DEPTH", int'(full_n), 0);
        push(9'h155);
        check("R7 still full", int'(full_n), 0);
        for (int k = 0; k < DEPTH; k++) begin
            rd_stb = 1;
            @(negedge clk);
            rd_stb = 0;
            if (int'(rd_data) != ((k * 7 + 3) & 9'h1FF))
                check("R7 contents intact", int'(rd_data), (k * 7 + 3) & 9'h1FF);
        end
        check("R7 last word", int'(rd_data), ((DEPTH - 1) * 7 + 3) & 9'h1FF);
        check("R7 empty after DEPTH reads", int'(empty_n), 0);
    endtask

    task automatic t_empty_read();
        do_reset(0, 0, 0);
        push(9'h1C3);
        pop_expect("R8 setup", 9'h1C3);
        pop_expect("R8 empty read holds", 9'h1C3);
        check("R8 stays empty", int'(empty_n), 0);
        push(9'h02E);
        pop_expect("R8 pointer unmoved", 9'h02E);
    endtask

    task automatic t_retransmit();
        do_reset(0, 0, 0);
        for (int k = 0; k < 4; k++) push(9'h100 + k);
        pop_expect("R9 pre A", 9'h100);
        pop_expect("R9 pre B", 9'h101);
        rt_stb = 1;
        @(negedge clk);
        rt_stb = 0;
        check("R9 nonempty after rt", int'(empty_n), 1);
        for (int k = 0; k < 4; k++) pop_expect("R9 replay", 9'h100 + k);
        check("R9 empty after replay", int'(empty_n), 0);
    endtask

    task automatic t_simul();
        do_reset(1, 1, 0);
        for (int k = 0; k < STEP + 1; k++) push(9'h040 + k);
        check("R10 setup fill", int'(fill_n), 0);
        wr_stb = 1; rd_stb = 1; wr_data = 9'h0FF;
        @(negedge clk);
        idle_inputs();
        check("R10 read word", int'(rd_data), 9'h040);
        check("R10 fill unchanged", int'(fill_n), 0);
        pop_expect("R10 next word", 9'h041);
        check("R10 count kept", int'(fill_n), 1);
    endtask

    task automatic t_cascade();
        cascade_mode = 1;
        do_reset(0, 0, 0);
        for (int k = 0; k < DEPTH / 2 + 8; k++) push(k);
        check("R11 fill off", int'(fill_n), 1);
        pop_expect("R11 first", 0);
        rt_stb = 1;
        @(negedge clk);
        rt_stb = 0;
        pop_expect("R11 rt ignored", 1);
        cascade_mode = 0;
        @(negedge clk);
        check("R11 fill back on", int'(fill_n), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_order();
        t_wr_code();
        t_bus_code();
        t_default_and_fill();
        t_full();
        t_empty_read();
        t_retransmit();
        t_simul();
        t_cascade();
        done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule